// File: doc/BRIEF.md
# Per-Field CSR Register Bank

This block is a single control/status register made of typed fields. Each field has a kind, fixed at elaboration: plain read-write, write-one-to-clear, write-one-to-set, read-only or write-only. The three read-write kinds keep their own flip-flops. Read-only and write-only fields have none and pass signals straight between the bus and the peripheral. Whether a field has storage is therefore decided field by field, not for the register as a whole.

The bus side has one read strobe and one write strobe for the whole register, write data, and registered read data. The peripheral side gives every field its own strobes. It also sees the write data, which is the next value, and the stored data, which is the current value, in the same cycle. A peripheral can set bits of a write-one-to-clear field through a set input, which is how it raises event flags.

The register can be placed in an access group that allows only reads or only writes. A field mix that breaks the group's rule stops elaboration.

Top module: `csr_field_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stored field loads its slice of `RST_VAL` and `bus_rd_data` becomes zero.
- R2: Fields are packed from bit 0 upward in declaration order. Default layout: bits 3:0 read-write, bits 7:4 write-one-to-clear, bits 15:8 read-only, bits 23:16 write-only, bits 27:24 write-one-to-set.
- R3: In a read-write field, `fld_data` always shows the stored value. In the cycle where `bus_wr_stb` is high it still shows the old value, and from the next cycle it shows the written value. Without a write strobe it does not change.
- R4: For a stored field, the value returned on a bus read equals its `fld_data`.
- R5: A write to a write-one-to-clear field clears each stored bit where the write data holds a 1 and leaves bits written with 0 unchanged.
- R6: A 1 on a `fld_set` bit of a write-one-to-clear field sets that bit at the next edge, with or without a bus write. If a set and a clear reach the same bit in one cycle, the set wins.
- R7: A write to a write-one-to-set field ORs the write data into the stored bits. No bus write clears such a bit.
- R8: A read-only field returns `fld_rd_in` on a bus read. It has no storage, so bus writes leave its read value unchanged, and its `fld_data` and `fld_w_data` bits are 0.
- R9: A write-only field drives `fld_w_data` combinationally from `bus_wr_data` whether or not the strobe is high. Its `fld_data` bits are 0, and it reads back as 0.
- R10: `bus_rd_data` is captured at the edge where `bus_rd_strobe` is high, so it is valid the cycle after the strobe. It holds its value while no read strobe is present.
- R11: The group rule rejects a register that has any writable field in a read-only group, or any readable field in a write-only group. An unrestricted group accepts every mix.
- R12: `fld_w_stb[i]` follows `bus_wr_stb` only for writable fields, and `fld_r_stb[i]` follows `bus_rd_stb` only for readable fields. Default masks: write 5'b11011, read 5'b10111 (bit i is field i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd_stb | input | 1 | Register read strobe from the bus |
| bus_wr_stb | input | 1 | Register write strobe from the bus |
| bus_wr_data | input | REG_W | Write data from the bus |
| bus_rd_data | output | REG_W | Registered read data to the bus |
| fld_rd_in | input | REG_W | Peripheral values for read-only fields |
| fld_set | input | REG_W | Peripheral set bits for write-one-to-clear fields |
| fld_data | output | REG_W | Stored values of stored fields (0 elsewhere) |
| fld_w_data | output | REG_W | Bus write data for writable fields (0 elsewhere) |
| fld_w_stb | output | NUM_FIELDS | Per-field write strobe |
| fld_r_stb | output | NUM_FIELDS | Per-field read strobe |

## Verification
The bench builds the default five-field register, which has one field of every kind at uneven widths and offsets. A single write or read therefore exercises all storage variants, the pass-through paths, packing at each field boundary and both strobe masks. The reset value gives the write-one-to-clear and write-one-to-set fields non-zero starting bits, so clears, sets and the set-over-clear collision can be seen from the first write. The group rule is checked through the package function for all three group modes against every mix of readable and writable fields.

// File: rtl/csr_fld_pkg.sv
// Shared types and elaboration-time rules for the per-field register.
// Assumes: field kinds and group modes are fixed by parameters.
package csr_fld_pkg;

    typedef enum logic [2:0] {
        FK_RO  = 3'd0,
        FK_WO  = 3'd1,
        FK_RW  = 3'd2,
        FK_W1C = 3'd3,
        FK_W1S = 3'd4
    } fld_kind_e;

    typedef enum logic [1:0] {
        GRP_ANY = 2'd0,
        GRP_RO  = 2'd1,
        GRP_WO  = 2'd2
    } grp_mode_e;

    // Field owns flip-flops
    function automatic bit kind_stored(fld_kind_e k);
        return (k == FK_RW) || (k == FK_W1C) || (k == FK_W1S);
    endfunction

    // Field returns something on a bus read
    function automatic bit kind_readable(fld_kind_e k);
        return k != FK_WO;
    endfunction

    // Field accepts bus writes
    function automatic bit kind_writable(fld_kind_e k);
        return k != FK_RO;
    endfunction

    // R11: group legality for a register with the given access mix
    function automatic bit grp_allows(grp_mode_e g, bit has_rd, bit has_wr);
        case (g)
            GRP_RO:  return !has_wr;
            GRP_WO:  return !has_rd;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/csr_fld_store.sv
// Storage element for one read-write style field.
// Assumes: KIND is FK_RW, FK_W1C or FK_W1S; set is used by FK_W1C only.
module csr_fld_store
    import csr_fld_pkg::*;
#(
    parameter int unsigned W    = 4,
    parameter fld_kind_e   KIND = FK_RW,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] set,
    output logic [W-1:0] data
);

    logic [W-1:0] nxt;

    // Next-state rule picked by field kind
    if (KIND == FK_W1C) begin : g_w1c
        always_comb nxt = (wr_stb ? (data & ~wr_data) : data) | set;
    end else if (KIND == FK_W1S) begin : g_w1s
        always_comb nxt = wr_stb ? (data | wr_data) : data;
    end else begin : g_rw
        always_comb nxt = wr_stb ? wr_data : data;
    end

    // Stored value register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) data <= RST;
        else        data <= nxt;
    end

    if (KIND == FK_RW) begin : g_rw_chk
        AST_RW_NEXT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |=> data == $past(wr_data)); // R3
        AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb |=> $stable(data)); // R3
    end
    if (KIND == FK_W1C) begin : g_w1c_chk
        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && set == '0) |=> (data & $past(wr_data)) == '0); // R5
        AST_W1C_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set != '0) |=> (data & $past(set)) == $past(set)); // R6
    end
    if (KIND == FK_W1S) begin : g_w1s_chk
        AST_W1S_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |=> (data & $past(data)) == $past(data)); // R7
    end

endmodule

// File: rtl/csr_fld_slot.sv
// One field of the register: storage or pass-through, plus its strobes.
// Assumes: all inputs are already sliced to this field's bits.
module csr_fld_slot
    import csr_fld_pkg::*;
#(
    parameter int unsigned W    = 4,
    parameter fld_kind_e   KIND = FK_RW,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rd_stb,
    input  logic         bus_wr_stb,
    input  logic [W-1:0] bus_wr_data,
    input  logic [W-1:0] periph_rd,
    input  logic [W-1:0] periph_set,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] data,
    output logic [W-1:0] w_data,
    output logic         w_stb,
    output logic         r_stb
);

    localparam bit STORED   = kind_stored(KIND);
    localparam bit READABLE = kind_readable(KIND);
    localparam bit WRITABLE = kind_writable(KIND);

    if (STORED) begin : g_stored
        logic [W-1:0] q;
        csr_fld_store #(.W(W), .KIND(KIND), .RST(RST)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (bus_wr_stb),
            .wr_data (bus_wr_data),
            .set     (periph_set),
            .data    (q)
        );
        // Stored value feeds both peripheral and bus read path
        assign data   = q;
        assign rd_val = q;
    end else begin : g_wire
        // No storage: read path comes straight from the peripheral
        assign data   = '0;
        assign rd_val = READABLE ? periph_rd : '0;
    end

    // Write data and strobes gated by the field's access kind
    assign w_data = WRITABLE ? bus_wr_data : '0;
    assign w_stb  = WRITABLE & bus_wr_stb;
    assign r_stb  = READABLE & bus_rd_stb;

endmodule

// File: rtl/csr_rd_capture.sv
// Registered bus read data, loaded on the read strobe.
// Assumes: rd_val is the combinational assembly of all fields.
module csr_rd_capture #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic [W-1:0] rd_val,
    output logic [W-1:0] rd_data
);

    // Capture on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= rd_val;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R10

endmodule

// File: rtl/csr_field_reg.sv
// Per-field control/status register: fields packed from bit 0 upward,
// each with its own storage choice; registered bus read data.
// Assumes: REG_W equals the sum of FIELD_W; field kinds obey GROUP.
module csr_field_reg
    import csr_fld_pkg::*;
#(
    parameter int unsigned NUM_FIELDS            = 5,
    parameter int unsigned FIELD_W [NUM_FIELDS]  = '{4, 4, 8, 8, 4},
    parameter fld_kind_e   FIELD_KIND [NUM_FIELDS] = '{FK_RW, FK_W1C, FK_RO, FK_WO, FK_W1S},
    parameter int unsigned REG_W                 = 28,
    parameter logic [REG_W-1:0] RST_VAL          = 28'h20000A5,
    parameter grp_mode_e   GROUP                 = GRP_ANY
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd_stb,
    input  logic                  bus_wr_stb,
    input  logic [REG_W-1:0]      bus_wr_data,
    output logic [REG_W-1:0]      bus_rd_data,
    input  logic [REG_W-1:0]      fld_rd_in,
    input  logic [REG_W-1:0]      fld_set,
    output logic [REG_W-1:0]      fld_data,
    output logic [REG_W-1:0]      fld_w_data,
    output logic [NUM_FIELDS-1:0] fld_w_stb,
    output logic [NUM_FIELDS-1:0] fld_r_stb
);

    // Bit offset of field idx: sum of the widths declared before it
    function automatic int unsigned fld_lsb(int unsigned idx);
        int unsigned s = 0;
        for (int unsigned j = 0; j < idx; j++) s += FIELD_W[j];
        return s;
    endfunction

    // Any field of the register is readable
    function automatic bit any_readable();
        bit r = 1'b0;
        for (int unsigned j = 0; j < NUM_FIELDS; j++) r |= kind_readable(FIELD_KIND[j]);
        return r;
    endfunction

    // Any field of the register is writable
    function automatic bit any_writable();
        bit r = 1'b0;
        for (int unsigned j = 0; j < NUM_FIELDS; j++) r |= kind_writable(FIELD_KIND[j]);
        return r;
    endfunction

    localparam int unsigned PACKED_W = fld_lsb(NUM_FIELDS);
    localparam bit          GRP_OK   = grp_allows(GROUP, any_readable(), any_writable());

    if (PACKED_W != REG_W) begin : g_bad_width
        $error("csr_field_reg: REG_W differs from the sum of field widths");
    end
    if (!GRP_OK) begin : g_bad_group
        $error("csr_field_reg: field access kinds conflict with the group mode"); // R11
    end

    logic [REG_W-1:0] rd_val;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam int unsigned LSB = fld_lsb(i);
        localparam int unsigned W   = FIELD_W[i];
        csr_fld_slot #(
            .W    (W),
            .KIND (FIELD_KIND[i]),
            .RST  (RST_VAL[LSB +: W])
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .bus_rd_stb  (bus_rd_stb),
            .bus_wr_stb  (bus_wr_stb),
            .bus_wr_data (bus_wr_data[LSB +: W]),
            .periph_rd   (fld_rd_in[LSB +: W]),
            .periph_set  (fld_set[LSB +: W]),
            .rd_val      (rd_val[LSB +: W]),
            .data        (fld_data[LSB +: W]),
            .w_data      (fld_w_data[LSB +: W]),
            .w_stb       (fld_w_stb[i]),
            .r_stb       (fld_r_stb[i])
        );
    end

    csr_rd_capture #(.W(REG_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (bus_rd_stb),
        .rd_val  (rd_val),
        .rd_data (bus_rd_data)
    );

    AST_STB_FOLLOW_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_stb |-> fld_w_stb == '0); // R12

endmodule

// File: tb/csr_field_reg_tb.sv
// Scoreboard bench: driver tasks queue expectations, monitor compares.
module csr_field_reg_tb_top;
    import csr_fld_pkg::*;

    localparam int REG_W = 28;
    localparam int NF    = 5;
    localparam logic [REG_W-1:0] WMASK = 28'hFFF00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rd_stb = 1'b0, bus_wr_stb = 1'b0;
    logic [REG_W-1:0] bus_wr_data = '0, bus_rd_data;
    logic [REG_W-1:0] fld_rd_in = '0, fld_set = '0;
    logic [REG_W-1:0] fld_data, fld_w_data;
    logic [NF-1:0]    fld_w_stb, fld_r_stb;

    always #10 clk = ~clk; // 50 MHz

    csr_field_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .fld_rd_in(fld_rd_in),
        .fld_set(fld_set), .fld_data(fld_data), .fld_w_data(fld_w_data),
        .fld_w_stb(fld_w_stb), .fld_r_stb(fld_r_stb)
    );

    typedef enum int {S_RD, S_DATA, S_WDATA, S_WSTB, S_RSTB} sel_e;
    typedef struct {
        string      req;
        sel_e       sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    // Reference model of stored fields
    logic [3:0] m_rw, m_w1c, m_w1s;

    function automatic logic [31:0] model_data();
        return {4'h0, m_w1s, 8'h00, 8'h00, m_w1c, m_rw};
    endfunction
    function automatic logic [31:0] model_read();
        return {4'h0, m_w1s, 8'h00, fld_rd_in[15:8], m_w1c, m_rw};
    endfunction
    function automatic logic [31:0] observe(sel_e s);
        case (s)
            S_RD:    return {4'h0, bus_rd_data};
            S_DATA:  return {4'h0, fld_data};
            S_WDATA: return {4'h0, fld_w_data};
            S_WSTB:  return {27'h0, fld_w_stb};
            default: return {27'h0, fld_r_stb};
        endcase
    endfunction

    task automatic push(string req, sel_e s, logic [31:0] e);
        item_t it;
        it.req = req; it.sel = s; it.exp = e;
        q.push_back(it);
    endtask

    // Monitor: compares queued expectations away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = observe(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        m_rw = 4'h5; m_w1c = 4'hA; m_w1s = 4'h2;
        @(negedge clk); rst_n = 1'b1;
        push("R1", S_DATA, model_data());
        push("R1", S_RD, 32'h0);
    endtask

    task automatic bus_write(logic [REG_W-1:0] wd, logic [3:0] st);
        @(negedge clk);
        bus_wr_stb = 1'b1; bus_wr_data = wd; fld_set[7:4] = st;
        push("R3", S_DATA, model_data());     // old value while strobe is high
        push("R9", S_WDATA, {4'h0, wd & WMASK});
        push("R12", S_WSTB, 32'b11011);
        @(posedge clk);
        m_rw  = wd[3:0];
        m_w1c = (m_w1c & ~wd[7:4]) | st;
        m_w1s = m_w1s | wd[27:24];
        @(negedge clk);
        bus_wr_stb = 1'b0; fld_set = '0;
        push("R3", S_DATA, model_data());     // new value next cycle
        push("R12", S_WSTB, 32'h0);
    endtask

    task automatic set_pulse(logic [3:0] st);
        @(negedge clk); fld_set[7:4] = st;
        @(posedge clk); m_w1c = m_w1c | st;
        @(negedge clk); fld_set = '0;
        push("R6", S_DATA, model_data());
    endtask

    task automatic bus_read(string req);
        logic [31:0] e;
        @(negedge clk); bus_rd_stb = 1'b1;
        push("R12", S_RSTB, 32'b10111);
        @(posedge clk); e = model_read();
        @(negedge clk); bus_rd_stb = 1'b0;
        push(req, S_RD, e);
        push("R12", S_RSTB, 32'h0);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] hold;
        do_reset();                                 // R1
        // R2 R3 R5 R7 R8: RW=9, W1C clears bit1, RO written (ignored), WO=5A, W1S |= 1
        bus_write(28'h15AFF29, 4'h0);
        fld_rd_in[15:8] = 8'hC3;
        bus_read("R4");                             // R2 R4 R8 R9 layout
        // R10: no strobe, input changes, read data holds
        @(negedge clk); fld_rd_in[15:8] = 8'h3C;
        @(negedge clk); push("R10", S_RD, model_read() ^ {16'h0, 8'hFF, 8'h0});
        bus_read("R8");                             // RO reflects new input
        // R6: set and clear hit the same bits; set wins
        bus_write(28'h0000 << 0 | 28'h00000F0 | {24'h0, 4'h0} | 28'h0000009, 4'h5);
        set_pulse(4'h2);                            // R6 set without write
        bus_write(28'h4000009, 4'h0);               // R7 OR in bit 2
        bus_write(28'h0000009, 4'h0);               // R7 zero write keeps bits
        bus_read("R7");
        // R3 R9: data changes without strobe
        @(negedge clk); bus_wr_data = 28'h0AB0006;
        push("R9", S_WDATA, {4'h0, 28'h0AB0006 & WMASK});
        @(negedge clk); push("R3", S_DATA, model_data());
        hold = m_w1c;
        bus_write(28'h0000050, 4'h0);               // R5 clears bits 2 and 0 of W1C
        push("R5", S_DATA, {4'h0, m_w1s, 16'h0, hold & ~4'h5, 4'h0});
        // R11: group rule
        n_chk++; if (grp_allows(GRP_RO, 1'b1, 1'b1) !== 1'b0) begin n_fail++; $display("FAIL R11 actual=1 expected=0"); end
        n_chk++; if (grp_allows(GRP_RO, 1'b1, 1'b0) !== 1'b1) begin n_fail++; $display("FAIL R11 actual=0 expected=1"); end
        n_chk++; if (grp_allows(GRP_WO, 1'b1, 1'b1) !== 1'b0) begin n_fail++; $display("FAIL R11 actual=1 expected=0"); end
        n_chk++; if (grp_allows(GRP_WO, 1'b0, 1'b1) !== 1'b1) begin n_fail++; $display("FAIL R11 actual=0 expected=1"); end
        n_chk++; if (grp_allows(GRP_ANY, 1'b1, 1'b1) !== 1'b1) begin n_fail++; $display("FAIL R11 actual=0 expected=1"); end
        do_reset();                                 // R1 again mid-run
        bus_read("R1");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule